// File: doc/BRIEF.md
# Per-Branch Two-Level Direction Predictor

This block predicts whether a conditional branch will be taken by using two tables in series. The first is a branch history table. It is indexed by a slice of the program counter and stores, for each entry, the shift register of recent outcomes of the branches that land on it. There are no tags, so unrelated branches can share an entry. The history read from that entry then indexes the second table, a pattern table of 2-bit saturating counters. The top bit of the selected counter is the prediction. The lookup path is purely combinational, from `lookup_pc` to `pred_taken`, so a fetch stage can use the answer in the same cycle.

The execute stage reports each branch outcome on a valid/ready resolve port. A transfer happens on a clock edge where `resolve_valid` and `resolve_ready` are both high. On that edge two things change. The counter selected by the branch's current history moves one step toward the reported outcome. The branch's history then shifts left and takes the outcome as its new LSB. After reset the block spends a fixed number of cycles sweeping both tables to their initial state. During that sweep it holds `resolve_ready` and `pred_valid` low. Once the sweep ends, `resolve_ready` stays high and a sender is never back-pressured again. A sender that raises `resolve_valid` during the sweep must hold its data until `resolve_ready` rises.

Top module: `lhp_predictor`

## Requirements
- R1: After reset is released, `resolve_ready` and `pred_valid` stay low for exactly max(HIST_DEPTH, 2^HIST_LEN) rising edges (1024 with the defaults), then both go high. The two signals always carry the same value.
- R2: Once the sweep has finished, every history entry is zero and every counter holds 01 (weakly not-taken), so any lookup reports not-taken until a resolve has been accepted.
- R3: `pred_taken` is combinational. It equals bit 1 of the counter whose index is the history value stored for `lookup_pc`. Branches whose histories are equal therefore share one counter.
- R4: The history table index is `pc[PC_LSB+HIST_IDX_W-1:PC_LSB]`, which is bits 11:2 with the defaults. Program counters that differ only outside that slice map to the same entry, and bits 1:0 are ignored.
- R5: An accepted resolve replaces the branch's history h with {h[HIST_LEN-2:0], taken}.
- R6: An accepted resolve moves the counter at the pre-update history index up by one when taken and down by one when not taken. The counter saturates at 3 and at 0.
- R7: No cycle without an accepted resolve changes either table once the sweep is over. Changes on `resolve_pc` or `resolve_taken` while `resolve_valid` is low leave every later prediction unchanged.
- R8: Once `resolve_ready` has risen, it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; starts the table sweep |
| lookup_pc | input | PC_W | Address of the branch being predicted |
| pred_valid | output | 1 | High once the tables are initialised |
| pred_taken | output | 1 | Predicted direction for `lookup_pc` (1 = taken) |
| resolve_valid | input | 1 | A resolved branch outcome is offered |
| resolve_ready | output | 1 | Block can accept a resolve this cycle |
| resolve_pc | input | PC_W | Address of the resolved branch |
| resolve_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
Some properties are checked on every cycle: the length of the post-reset sweep, `pred_valid` agreeing with `resolve_ready`, ready never falling again, the history shift on back-to-back resolves of the same branch, and stable predictions when no resolve is accepted. Other behaviour only shows up in the bench scenarios: the counter stepping and saturating at either end, aliasing across address bits outside the index slice, two branches sharing one counter through equal histories, and the predictor learning a repeating loop pattern. The bench checks these against a model of both tables built from the requirements.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b01;
  localparam ctr_t CTR_MAX  = 2'b11;
  localparam ctr_t CTR_MIN  = 2'b00;

  // one saturating step toward the observed outcome
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? cur : cur + 2'd1;
    else       nxt = (cur == CTR_MIN) ? cur : cur - 2'd1;
    return nxt;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lhp_init_seq.sv
module lhp_init_seq #(
  parameter int unsigned SPAN = 1024,
  localparam int unsigned SW  = (SPAN > 1) ? $clog2(SPAN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          busy,
  output logic [SW-1:0] idx
);

  localparam logic [SW-1:0] LAST = SW'(SPAN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST) busy <= 1'b0;
      else             idx  <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned LEN   = 10,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic [IW-1:0]  rd_idx,
  output logic [LEN-1:0] rd_hist,
  input  logic [IW-1:0]  upd_idx,
  output logic [LEN-1:0] upd_hist,
  input  logic           upd_en,
  input  logic           upd_taken,
  input  logic           clr_en,
  input  logic [IW-1:0]  clr_idx
);

  logic [LEN-1:0] mem [DEPTH];
  logic [LEN-1:0] shifted;

  assign rd_hist  = mem[rd_idx];
  assign upd_hist = mem[upd_idx];

  generate
    if (LEN > 1) begin : g_shift
      assign shifted = {upd_hist[LEN-2:0], upd_taken};
    end else begin : g_single
      assign shifted = upd_taken;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr_en)      mem[clr_idx] <= '0;
    else if (upd_en) mem[upd_idx] <= shifted;
  end

endmodule

// File: rtl/lhp_pattern_table.sv
module lhp_pattern_table
  import lhp_pkg::*;
#(
  parameter int unsigned LEN = 10,
  localparam int unsigned DEPTH = 1 << LEN
) (
  input  logic           clk,
  input  logic [LEN-1:0] rd_idx,
  output logic           rd_taken,
  input  logic [LEN-1:0] upd_idx,
  input  logic           upd_en,
  input  logic           upd_taken,
  input  logic           clr_en,
  input  logic [LEN-1:0] clr_idx
);

  ctr_t mem [DEPTH];
  ctr_t rd_ctr;
  ctr_t upd_cur;

  assign rd_ctr   = mem[rd_idx];
  assign rd_taken = rd_ctr[1];
  assign upd_cur  = mem[upd_idx];

  always_ff @(posedge clk) begin
    if (clr_en)      mem[clr_idx] <= CTR_INIT;
    else if (upd_en) mem[upd_idx] <= ctr_step(upd_cur, upd_taken);
  end

endmodule

// File: rtl/lhp_predictor.sv
module lhp_predictor
  import lhp_pkg::*;
#(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned PC_LSB     = 2,
  parameter int unsigned HIST_LEN   = 10,
  parameter int unsigned HIST_DEPTH = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lookup_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  input  logic            resolve_valid,
  output logic            resolve_ready,
  input  logic [PC_W-1:0] resolve_pc,
  input  logic            resolve_taken
);

  localparam int unsigned HIST_IDX_W = $clog2(HIST_DEPTH);
  localparam int unsigned PHT_DEPTH  = 1 << HIST_LEN;
  localparam int unsigned SPAN       = max_of(HIST_DEPTH, PHT_DEPTH);
  localparam int unsigned SW         = (SPAN > 1) ? $clog2(SPAN) : 1;

  logic                  init_busy;
  logic [SW-1:0]         sweep_idx;
  logic                  fire;
  logic [HIST_IDX_W-1:0] look_idx;
  logic [HIST_IDX_W-1:0] upd_idx;
  logic [HIST_LEN-1:0]   look_hist;
  logic [HIST_LEN-1:0]   upd_hist_old;
  logic                  hist_clr_en;
  logic                  pht_clr_en;

  lhp_init_seq #(.SPAN(SPAN)) u_init (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (init_busy),
    .idx   (sweep_idx)
  );

  assign resolve_ready = !init_busy;
  assign pred_valid    = !init_busy;
  assign fire          = resolve_valid && resolve_ready;

  assign look_idx = lookup_pc[PC_LSB +: HIST_IDX_W];
  assign upd_idx  = resolve_pc[PC_LSB +: HIST_IDX_W];

  assign hist_clr_en = init_busy && ({1'b0, sweep_idx} < (SW+1)'(HIST_DEPTH));
  assign pht_clr_en  = init_busy && ({1'b0, sweep_idx} < (SW+1)'(PHT_DEPTH));

  lhp_hist_table #(.DEPTH(HIST_DEPTH), .LEN(HIST_LEN)) u_hist (
    .clk       (clk),
    .rd_idx    (look_idx),
    .rd_hist   (look_hist),
    .upd_idx   (upd_idx),
    .upd_hist  (upd_hist_old),
    .upd_en    (fire),
    .upd_taken (resolve_taken),
    .clr_en    (hist_clr_en),
    .clr_idx   (sweep_idx[HIST_IDX_W-1:0])
  );

  lhp_pattern_table #(.LEN(HIST_LEN)) u_pht (
    .clk       (clk),
    .rd_idx    (look_hist),
    .rd_taken  (pred_taken),
    .upd_idx   (upd_hist_old),
    .upd_en    (fire),
    .upd_taken (resolve_taken),
    .clr_en    (pht_clr_en),
    .clr_idx   (sweep_idx[HIST_LEN-1:0])
  );

endmodule

// File: rtl/lhp_checker.sv
module lhp_checker #(
  parameter int unsigned HIST_LEN = 10,
  parameter int unsigned SPAN     = 1024,
  parameter int unsigned PC_W     = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [PC_W-1:0]     lookup_pc,
  input logic                pred_valid,
  input logic                pred_taken,
  input logic                resolve_valid,
  input logic                resolve_ready,
  input logic [PC_W-1:0]     resolve_pc,
  input logic                resolve_taken,
  input logic [HIST_LEN-1:0] upd_hist_old
);

  logic [31:0] wait_cnt;
  logic        fire;
  assign fire = resolve_valid && resolve_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wait_cnt <= '0;
    else if (!resolve_ready) wait_cnt <= wait_cnt + 1'b1;
  end

  // R1: sweep lasts exactly SPAN edges
  p_sweep_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resolve_ready) |-> (wait_cnt == SPAN));

  // R1: lookup validity follows resolve readiness
  p_valid_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid == resolve_ready);

  // R8: no back-pressure after the sweep
  p_ready_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_ready |=> resolve_ready);

  // R5: same branch resolved twice in a row sees the shifted history
  generate
    if (HIST_LEN > 1) begin : g_shift_chk
      p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (!$stable(resolve_pc) ||
                  upd_hist_old == {$past(upd_hist_old[HIST_LEN-2:0]), $past(resolve_taken)}));
    end
  endgenerate

  // R7: without an accepted resolve the prediction for a fixed pc holds
  p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && resolve_ready) |=> (!$stable(lookup_pc) || $stable(pred_taken)));

endmodule

bind lhp_predictor lhp_checker #(
  .HIST_LEN (HIST_LEN),
  .SPAN     (SPAN),
  .PC_W     (PC_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .lookup_pc     (lookup_pc),
  .pred_valid    (pred_valid),
  .pred_taken    (pred_taken),
  .resolve_valid (resolve_valid),
  .resolve_ready (resolve_ready),
  .resolve_pc    (resolve_pc),
  .resolve_taken (resolve_taken),
  .upd_hist_old  (upd_hist_old)
);

// File: tb/lhp_predictor_tb_top.sv
`timescale 1ns/1ps
module lhp_predictor_tb_top;

  localparam int PC_W  = 32;
  localparam int HLEN  = 10;
  localparam int HDEP  = 1024;
  localparam int SPAN  = 1024;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] lookup_pc = '0;
  logic            pred_valid, pred_taken;
  logic            resolve_valid = 1'b0;
  logic            resolve_ready;
  logic [PC_W-1:0] resolve_pc = '0;
  logic            resolve_taken = 1'b0;

  int total = 0;
  int bad   = 0;
  item_t sb_q[$];

  logic [HLEN-1:0] hist_m [HDEP];
  logic [1:0]      ctr_m  [1 << HLEN];

  always #2 clk = ~clk;

  lhp_predictor #(.PC_W(PC_W), .PC_LSB(2), .HIST_LEN(HLEN), .HIST_DEPTH(HDEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .pred_valid(pred_valid),
    .pred_taken(pred_taken), .resolve_valid(resolve_valid), .resolve_ready(resolve_ready),
    .resolve_pc(resolve_pc), .resolve_taken(resolve_taken)
  );

  function automatic int hidx(input logic [PC_W-1:0] pc);
    return int'(pc[11:2]);
  endfunction

  function automatic logic model_pred(input logic [PC_W-1:0] pc);
    return ctr_m[hist_m[hidx(pc)]][1];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: present a lookup, queue the expected prediction
  task automatic lookup(input logic [PC_W-1:0] pc, input string tag);
    item_t it;
    lookup_pc = pc;
    it.exp = model_pred(pc);
    it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic resolve(input logic [PC_W-1:0] pc, input logic t);
    int h;
    resolve_valid = 1'b1;
    resolve_pc    = pc;
    resolve_taken = t;
    @(posedge clk); #1;
    resolve_valid = 1'b0;
    h = hidx(pc);
    if (t && ctr_m[hist_m[h]] != 2'd3) ctr_m[hist_m[h]] = ctr_m[hist_m[h]] + 2'd1;
    if (!t && ctr_m[hist_m[h]] != 2'd0) ctr_m[hist_m[h]] = ctr_m[hist_m[h]] - 2'd1;
    hist_m[h] = {hist_m[h][HLEN-2:0], t};
  endtask

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check({it.tag, " valid"}, 32'(pred_valid), 32'd1);
      check(it.tag, 32'(pred_taken), 32'(it.exp));
    end
  end

  initial begin
    #(4ns * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < HDEP; i++) hist_m[i] = '0;
    for (int i = 0; i < (1 << HLEN); i++) ctr_m[i] = 2'b01;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset ready", 32'(resolve_ready), 32'd0);
    check("R1 reset valid", 32'(pred_valid), 32'd0);
    rst_n = 1'b1;
    n = 0;
    while (n < SPAN + 10) begin
      @(posedge clk); #1;
      n++;
      if (resolve_ready) break;
    end
    check("R1 sweep length", 32'(n), 32'(SPAN));
    check("R1 valid after sweep", 32'(pred_valid), 32'd1);

    // R2: fresh tables predict not-taken
    lookup(32'h0000_0000, "R2 fresh");
    lookup(32'h0000_1234, "R2 fresh");
    lookup(32'h0000_FFFC, "R2 fresh");

    // R3/R6: two branches sharing a counter through equal histories
    resolve(32'h100, 1'b1);
    lookup(32'h100, "R3 after one taken");
    resolve(32'h100, 1'b1);
    lookup(32'h200, "R3 shared counter");
    check("R3 shared counter now taken", 32'(model_pred(32'h200)), 32'd1);

    // R5: repeating loop pattern T T T N
    for (int it = 0; it < 40; it++) begin
      for (int k = 0; k < 4; k++) begin
        lookup(32'h4000, "R5 loop pattern");
        resolve(32'h4000, (k != 3));
      end
    end

    // R6: saturation at both ends
    for (int k = 0; k < 14; k++) begin
      resolve(32'h800, 1'b1);
      lookup(32'h800, "R6 saturate up");
    end
    check("R6 top counter saturated", 32'(ctr_m[10'h3FF]), 32'd3);
    for (int k = 0; k < 14; k++) begin
      resolve(32'h800, 1'b0);
      lookup(32'h800, "R6 saturate down");
    end
    for (int k = 0; k < 4; k++) resolve(32'h804, 1'b0);
    lookup(32'h804, "R6 floor");

    // R4: aliasing through bits outside the index slice
    resolve(32'h0001_0A00, 1'b1);
    lookup(32'h0000_0A00, "R4 alias high bits");
    lookup(32'h0000_0A03, "R4 low bits ignored");
    lookup(32'h0000_1A00, "R4 alias bit 12");

    // R7: resolve inputs wiggle without valid
    for (int k = 0; k < 20; k++) begin
      resolve_pc = 32'h4000 + 32'(k * 4);
      resolve_taken = k[0];
      @(posedge clk); #1;
    end
    lookup(32'h4000, "R7 idle no change");
    lookup(32'h800,  "R7 idle no change");
    lookup(32'h200,  "R7 idle no change");

    // R8
    check("R8 ready still high", 32'(resolve_ready), 32'd1);

    @(posedge clk); #1;
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule